// File: doc/BRIEF.md
# Edge-Activity Watchdog Timer

This block supervises one external signal, typically a processor heartbeat or a clock, and reports when it has gone quiet. Any change of level on the monitored input, upward or downward, counts as a sign of life and restarts a timeout. If the timeout runs out with no change seen, a sticky fail flag rises. Downstream sequencing logic can combine that flag with other conditions to decide which supplies or resets to drive.

Time is measured in ticks of a shared timebase enable rather than in raw clock cycles, so one counter serves any clock frequency. A three-bit select picks the timeout as a base count doubled zero to six times. With the default base of 200 one-millisecond ticks, the range runs from 200 ms to 12.8 s. A one-cycle event pulse marks the moment the flag first rises, for logic that wants an edge rather than a level.

Top module: `edge_watchdog_top`

## Requirements
- R1: Rising and falling changes of `mon_in` both count as activity. Each passes a two-flop synchronizer: a change driven before clock edge k clears the count and the flag at edge k+2.
- R2: When `tick_en` has been high on L clock edges since the last activity (or since enabling) with no change seen, `wd_fail` rises. It stays high until activity is seen or `enable` is deasserted.
- R3: The tick count L is `BASE_TICKS` × 2^N, where N is the value of `tmo_sel` for codes 0 to 6. Code 7 gives the same count as code 6. The defaults give 200 to 12800 ticks.
- R4: Activity seen while `wd_fail` is high clears the flag and restarts the count from zero, so a further full L ticks must pass before it rises again.
- R5: While `enable` is low, the count is held at zero and `wd_fail` is low, which clears a raised flag on the next edge. After `enable` returns high, a full L ticks are needed to trip.
- R6: `tmo_pulse` is high for exactly one cycle: the cycle in which `wd_fail` first becomes high.
- R7: Clock edges with `tick_en` low do not advance the count, so without ticks no timeout occurs.
- R8: After synchronous reset, `wd_fail` and `tmo_pulse` are low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick enable, one clock per tick |
| mon_in | input | 1 | Monitored signal, asynchronous to clk |
| tmo_sel | input | 3 | Timeout select N: L = BASE_TICKS × 2^min(N,6) |
| enable | input | 1 | Watchdog enable; low holds the count at zero and clears the flag |
| wd_fail | output | 1 | Sticky fail flag: no activity within the timeout |
| tmo_pulse | output | 1 | One-cycle pulse when the fail flag rises |

## Verification
The bench predicts the exact cycle of each timeout pulse, counting from the cycle in which it changed the input. It then places a falling change just before the count would expire. A design that treats only rising changes as activity therefore trips early, and the pulse lands on the wrong cycle. Select codes 6 and 7 are both exercised: a decoder that shifts by the raw code would produce a timeout twice as long for code 7. The bench also stops the timebase ticks for several timeout lengths, drops the enable while the flag is high, and clears a raised flag with a new change. A design that counts clocks instead of ticks, keeps the flag through a disable, or resumes a half-finished count would show a spurious pulse, a stuck flag, or a pulse that comes too soon.

// File: rtl/edgewd_pkg.sv
package edgewd_pkg;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned MAX_SHIFT = 6;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic fail;
        logic pulse;
    } wd_out_t;

    // Saturating doubling exponent taken from the select code
    function automatic logic [2:0] sel_shift(input logic [SEL_W-1:0] sel);
        return (int'(sel) > int'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : 3'(sel);
    endfunction

endpackage

// File: rtl/wd_sync_edge.sv
module wd_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic act_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // either direction of change is activity
    assign act_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/wd_limit_decode.sv
module wd_limit_decode
    import edgewd_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 200,
    parameter int unsigned CNT_W      = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_TICKS);
    localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(BASE_TICKS) << MAX_SHIFT;

    always_comb begin
        limit = BASE_V << sel_shift(sel);
    end

    // R3
    limit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (limit >= BASE_V) && (limit <= TOP_V));

endmodule

// File: rtl/wd_timeout_core.sv
module wd_timeout_core
    import edgewd_pkg::*;
#(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             tick_en_i,
    input  logic             act_i,
    input  logic [CNT_W-1:0] limit_i,
    output wd_out_t          flags_o
);
    wd_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!enable_i) begin
                st_q  <= ST_OFF;
                cnt_q <= '0;
            end else if (act_i) begin
                st_q  <= ST_RUN;
                cnt_q <= '0;
            end else if (st_q != ST_TRIP) begin
                if (tick_en_i) begin
                    if (cnt_inc >= {1'b0, limit_i}) begin
                        st_q    <= ST_TRIP;
                        pulse_q <= 1'b1;
                    end else begin
                        st_q  <= ST_RUN;
                        cnt_q <= cnt_inc[CNT_W-1:0];
                    end
                end else begin
                    st_q <= ST_RUN;
                end
            end
        end
    end

    assign flags_o.fail  = (st_q == ST_TRIP);
    assign flags_o.pulse = pulse_q;

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R6
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (st_q == ST_TRIP) && ($past(st_q) != ST_TRIP));

    // R5
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (st_q != ST_TRIP) && (cnt_q == '0));

    // R4
    activity_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (enable_i && act_i) |=> (st_q != ST_TRIP) && (cnt_q == '0));

    // R2
    trip_needs_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_TRIP) |-> $past(tick_en_i) && ($past(cnt_inc) >= $past({1'b0, limit_i})));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !act_i && !tick_en_i) |=> $stable(cnt_q));

endmodule

// File: rtl/edge_watchdog_top.sv
module edge_watchdog_top
    import edgewd_pkg::*;
#(
    parameter int unsigned BASE_TICKS  = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             mon_in,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             enable,
    output logic             wd_fail,
    output logic             tmo_pulse
);
    localparam int unsigned CNT_W = $clog2(BASE_TICKS * (2 ** MAX_SHIFT) + 1);

    logic             act;
    logic [CNT_W-1:0] limit;
    wd_out_t          flags;

    wd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (mon_in),
        .act_o (act)
    );

    wd_limit_decode #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .sel   (tmo_sel),
        .limit (limit)
    );

    wd_timeout_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (enable),
        .tick_en_i (tick_en),
        .act_i     (act),
        .limit_i   (limit),
        .flags_o   (flags)
    );

    assign wd_fail   = flags.fail;
    assign tmo_pulse = flags.pulse;

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !wd_fail && !tmo_pulse);

endmodule

// File: tb/tb_edge_watchdog_top.sv
module tb_edge_watchdog_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 10;

    logic       clk     = 1'b0;
    logic       rst     = 1'b1;
    logic       tick_en = 1'b1;
    logic       mon_in  = 1'b0;
    logic       enable  = 1'b0;
    logic [2:0] tmo_sel = 3'd0;
    logic       wd_fail;
    logic       tmo_pulse;

    int compared   = 0;
    int mismatched = 0;
    int cyc        = 0;
    int exp_q[$];

    edge_watchdog_top #(.BASE_TICKS(BASE)) dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .mon_in    (mon_in),
        .tmo_sel   (tmo_sel),
        .enable    (enable),
        .wd_fail   (wd_fail),
        .tmo_pulse (tmo_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int lim(input int sel);
        return BASE << ((sel > 6) ? 6 : sel);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: change the input and predict the pulse cycle
    task automatic toggle(input bit expect_pulse, input int sel);
        mon_in = ~mon_in;
        if (expect_pulse) exp_q.push_back(cyc + 3 + lim(sel));
    endtask

    // monitor: pop expected pulse cycles and compare
    int   exp_c;
    logic pulse_d = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_d) check("R6 pulse lasts one cycle", int'(tmo_pulse), 0);
            if (tmo_pulse) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected timeout pulse at cycle", cyc, -1);
                end else begin
                    exp_c = exp_q.pop_front();
                    check("R2/R3 timeout pulse cycle", cyc, exp_c);
                    check("R6 flag high with pulse", int'(wd_fail), 1);
                end
            end
            pulse_d <= tmo_pulse;
        end
    end

    task automatic run_all();
        int c;
        step(3);
        rst = 1'b0;
        step(1);
        check("R8 reset fail low", int'(wd_fail), 0);
        check("R8 reset pulse low", int'(tmo_pulse), 0);
        step(30);
        check("R5 disabled keeps flag low", int'(wd_fail), 0);

        // first enable, select 0
        enable = 1'b1;
        exp_q.push_back(cyc + lim(0));
        step(lim(0) + 3);
        check("R2 flag sticky after timeout", int'(wd_fail), 1);

        // R4: activity clears the flag two edges later, count restarts
        c = cyc;
        toggle(1, 0);
        step(2);
        check("R4 flag still high before sync latency", int'(wd_fail), 1);
        step(1);
        check("R4 flag cleared by activity", int'(wd_fail), 0);
        step(lim(0) + 3);
        check("R4 flag back after full timeout", int'(wd_fail), 1);

        // R1: falling and rising changes both restart
        tmo_sel = 3'd2;
        toggle(0, 2);
        step(3);
        check("R1 falling change clears flag", int'(wd_fail), 0);
        step(lim(2) - 5);
        toggle(0, 2);
        step(lim(2) - 2);
        check("R1 no trip while changes keep coming", int'(wd_fail), 0);
        toggle(1, 2);
        step(lim(2) + 4);
        check("R1 trip after last falling change", int'(wd_fail), 1);

        // R3: larger select codes, code 7 saturates at code 6
        for (int s = 3; s <= 7; s += 2) begin
            tmo_sel = 3'(s);
            toggle(1, s);
            step(lim(s) + 4);
            check("R3 flag after selected timeout", int'(wd_fail), 1);
        end
        tmo_sel = 3'd6;
        toggle(1, 6);
        step(lim(6) + 4);
        check("R3 code 6 timeout", int'(wd_fail), 1);

        // R7: no ticks, no timeout
        tmo_sel = 3'd0;
        tick_en = 1'b0;
        toggle(0, 0);
        step(3 * lim(0));
        check("R7 no timeout without ticks", int'(wd_fail), 0);
        tick_en = 1'b1;
        exp_q.push_back(cyc + lim(0));
        step(lim(0) + 3);
        check("R7 trip once ticks resume", int'(wd_fail), 1);

        // R5: disable while failed, then re-enable
        enable = 1'b0;
        step(1);
        check("R5 disable clears flag", int'(wd_fail), 0);
        step(3 * lim(0));
        check("R5 no trip while disabled", int'(wd_fail), 0);
        enable = 1'b1;
        exp_q.push_back(cyc + lim(0));
        step(lim(0) + 3);
        check("R5 full timeout after re-enable", int'(wd_fail), 1);

        step(4);
        check("R2 every predicted pulse seen", exp_q.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                compared++;
                mismatched++;
                $display("FAIL watchdog expired: actual hung expected done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule